// File: doc/BRIEF.md
# Quad Mask Compress and Expand Unit

This unit converts between lane masks and quad masks for pixel work done in quads of four lanes. Each lane mask is split into 4-bit groups, one group per quad. In compress mode the unit packs each group into one bit of a dense quad mask. In expand mode it widens any group that has an active lane to all four lanes, which gives the whole-quad form of the mask.

A width select chooses between a 32-bit lane mask (8 quads) and a 64-bit lane mask (16 quads). A condition flag reports whether the result has any bit set. The unit is registered: an operation is accepted on a cycle with the input valid high, and the result, the flag and an output valid appear on the following cycle.

Top module: `qmask_unit`

## Requirements
- R1: In compress mode (`opSel` = 0), result bit g is 1 exactly when operand bits 4g..4g+3 contain at least one 1.
- R2: In compress mode, result bits from position 8 upward are 0 in 32-bit mode, and result bits from position 16 upward are 0 in 64-bit mode.
- R3: In expand mode (`opSel` = 1), result bits 4g..4g+3 are all 1 when operand group g is non-zero and all 0 otherwise.
- R4: In 32-bit mode (`wideSel` = 0), operand bits 32..63 have no effect on the result, and result bits 32..63 are 0.
- R5: `flag` is 1 when the presented result is non-zero and 0 when it is zero, in both modes.
- R6: `outValid` is high in the cycle after a cycle with `inValid` high and low otherwise, and the result and flag for that operation are presented alongside it.
- R7: After reset, `outValid`, `result` and `flag` are all 0.
- R8: In cycles that follow a cycle with `inValid` low, `result` and `flag` keep their previous values.
- R9: In expand mode, every operand bit that is examined and set is also set in the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Accept an operation this cycle |
| opSel | input | 1 | 0 = compress, 1 = expand |
| wideSel | input | 1 | 0 = 32-bit operand, 1 = 64-bit operand |
| operand | input | 64 | Lane mask to convert |
| outValid | output | 1 | Result and flag belong to an accepted operation |
| result | output | 64 | Converted mask |
| flag | output | 1 | Result non-zero |

## Verification
The assertions assume that `opSel`, `wideSel` and `operand` hold known values in every cycle where `inValid` is high, because the next-cycle checks compare against the sampled inputs. They assume nothing about the inputs in idle cycles. The stimulus sets all inputs together at the falling edge and uses only defined values. It drops `inValid` between bursts and also leaves garbage on the data inputs during idle cycles, so the hold behaviour is tested against inputs that really change.

// File: rtl/qmask_pkg.sv
package qmask_pkg;

  localparam int DATA_W   = 64;
  localparam int NARROW_W = 32;
  localparam int GRP_W    = 4;

  typedef enum logic {
    OP_PACK   = 1'b0,
    OP_SPREAD = 1'b1
  } qmask_op_e;

  typedef struct packed {
    logic loadEn;
    logic spreadMode;
    logic wideMode;
  } qmask_strobe_t;

endpackage

// File: rtl/qmask_ctrl.sv
module qmask_ctrl
  import qmask_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          opSel,
  input  logic          wideSel,
  output qmask_strobe_t strobe,
  output logic          outValid
);

  always_comb begin
    strobe.loadEn     = inValid;
    strobe.spreadMode = (qmask_op_e'(opSel) == OP_SPREAD);
    strobe.wideMode   = wideSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R6
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/qmask_datapath.sv
module qmask_datapath
  import qmask_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NW = NARROW_W,
  parameter int GW = GRP_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  qmask_strobe_t strobe,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] result,
  output logic          flag
);

  localparam int N_GRP        = DW / GW;
  localparam int N_GRP_NARROW = NW / GW;
  localparam logic [DW-1:0] NARROW_MASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};

  logic [DW-1:0]    opMasked;
  logic [N_GRP-1:0] anyBit;
  logic [DW-1:0]    spreadVal;
  logic [DW-1:0]    packVal;
  logic [DW-1:0]    nextRes;

  assign opMasked = strobe.wideMode ? operand : (operand & NARROW_MASK);

  for (genvar g = 0; g < N_GRP; g++) begin : gGrp
    assign anyBit[g] = |opMasked[g*GW +: GW];
    assign spreadVal[g*GW +: GW] = {GW{anyBit[g]}};
  end

  assign packVal = {{(DW-N_GRP){1'b0}}, anyBit};
  assign nextRes = strobe.spreadMode ? spreadVal : packVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      flag   <= 1'b0;
    end else if (strobe.loadEn) begin
      result <= nextRes;
      flag   <= |anyBit;
    end
  end

  // R2
  pack_narrow_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && !strobe.spreadMode && !strobe.wideMode)
      |=> (result[DW-1:N_GRP_NARROW] == '0));

  // R2
  pack_wide_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && !strobe.spreadMode && strobe.wideMode)
      |=> (result[DW-1:N_GRP] == '0));

  // R4
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && !strobe.wideMode) |=> (result[DW-1:NW] == '0));

  // R5
  flag_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |=> (flag == (result != '0)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadEn |=> ($stable(result) && $stable(flag)));

  // R9
  spread_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && strobe.spreadMode)
      |=> (($past(opMasked) & ~result) == '0));

endmodule

// File: rtl/qmask_unit.sv
module qmask_unit
  import qmask_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              opSel,
  input  logic              wideSel,
  input  logic [DATA_W-1:0] operand,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              flag
);

  qmask_strobe_t strobe;

  qmask_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .wideSel  (wideSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  qmask_datapath #(
    .DW (DATA_W),
    .NW (NARROW_W),
    .GW (GRP_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .operand (operand),
    .result  (result),
    .flag    (flag)
  );

  // R7
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && result == '0 && !flag));

endmodule

// File: tb/qmask_unit_test.sv
module qmask_unit_test;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] res;
    logic        flg;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        opSel = 1'b0;
  logic        wideSel = 1'b0;
  logic [63:0] operand = '0;
  logic        outValid;
  logic [63:0] result;
  logic        flag;

  int          nChecks = 0;
  int          nFails = 0;
  item_t       sbQ[$];
  logic [63:0] lastRes = '0;
  logic        lastFlg = 1'b0;
  logic [63:0] lfsr = 64'hACE1_2468_1357_BEEF;

  always #(CLK_PERIOD/2) clk = ~clk;

  qmask_unit uut (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .wideSel  (wideSel),
    .operand  (operand),
    .outValid (outValid),
    .result   (result),
    .flag     (flag)
  );

  function automatic item_t model(input logic op, input logic wide,
                                  input logic [63:0] x, input string tag);
    item_t it;
    it.res = '0;
    for (int g = 0; g < 16; g++) begin
      if (wide || g < 8) begin
        if (x[4*g +: 4] != 4'h0) begin
          if (op) it.res[4*g +: 4] = 4'hF;
          else    it.res[g] = 1'b1;
        end
      end
    end
    it.flg = (it.res != '0);
    it.tag = tag;
    return it;
  endfunction

  task automatic check(input string tag, input logic [64:0] act,
                       input logic [64:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic op, input logic wide,
                       input logic [63:0] x, input string tag);
    @(negedge clk);
    inValid = 1'b1;
    opSel   = op;
    wideSel = wide;
    operand = x;
    sbQ.push_back(model(op, wide, x, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      opSel   = lfsr[0];
      wideSel = lfsr[1];
      operand = ~lfsr;
      lfsr    = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      if (!outValid)
        check("R8 hold", {flag, result}, {lastFlg, lastRes});
    end
  endtask

  // monitor: pops one expectation per valid output
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sbQ.size() == 0) begin
        check("R6 unexpected valid", {64'd0, outValid}, 65'd0);
      end else begin
        item_t e;
        e = sbQ.pop_front();
        check(e.tag, {flag, result}, {e.flg, e.res});
        lastRes = e.res;
        lastFlg = e.flg;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state while held and just after release
    check("R7 reset", {flag, result, outValid}, 66'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 after release", {flag, result, outValid}, 66'd0);

    // R1 R2 R5: zero and all ones, both widths
    drive(1'b0, 1'b1, 64'h0, "R5 pack zero");
    drive(1'b0, 1'b1, '1, "R2 pack wide ones");
    drive(1'b0, 1'b0, '1, "R2 pack narrow ones");
    drive(1'b1, 1'b1, '1, "R3 spread wide ones");
    drive(1'b1, 1'b0, 64'h0, "R5 spread zero");
    idle(3);

    // R1: one bit in each group, each lane position
    for (int g = 0; g < 16; g++)
      drive(1'b0, 1'b1, 64'h1 << (4*g + (g % 4)), "R1 single group");
    idle(2);

    // R3 R9: patterns in expand mode
    drive(1'b1, 1'b1, 64'h1111_1111_1111_1111, "R3 low lanes");
    drive(1'b1, 1'b1, 64'h8000_0400_0020_0001, "R9 sparse");
    drive(1'b1, 1'b1, 64'h0F00_F00F_0000_00F0, "R3 mixed");
    drive(1'b1, 1'b0, 64'h0000_0000_1020_0304, "R3 narrow");
    idle(2);

    // R4: upper operand bits must not matter in narrow mode
    drive(1'b0, 1'b0, 64'hFFFF_FFFF_0000_0000, "R4 pack upper only");
    drive(1'b1, 1'b0, 64'hFFFF_FFFF_0000_0000, "R4 spread upper only");
    drive(1'b1, 1'b0, 64'h8000_0000_0000_0010, "R4 spread mixed");
    drive(1'b0, 1'b0, 64'hA5A5_A5A5_0000_8001, "R4 pack mixed");
    idle(4);

    // R6: random back to back and gapped traffic
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      drive(lfsr[5], lfsr[9], lfsr & {lfsr[31:0], lfsr[63:32]}, "R6 random");
      if (lfsr[3]) idle(1 + (i % 3));
    end
    idle(4);

    check("R6 all results seen", {33'd0, sbQ.size()}, 65'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule